// File: doc/BRIEF.md
# Inter-Processor Interrupt Hub

This block lets up to eleven processor agents signal one another through a single memory-mapped register window. A sender writes the trigger register to fire one-cycle pulses on the outbound trigger lines. The receiving side turns its inbound request lines into sticky status bits. Software masks and unmasks those bits through separate set-bit and clear-bit strobe registers. One registered interrupt line tells the local processor that an unmasked request is pending.

Each agent channel occupies one fixed bit position in every register word. Channel 0 is bit 0, channels 1–2 are bits 8–9, channels 3–6 are bits 16–19 and channels 7–10 are bits 24–27. External lines are indexed by channel number, from 0 to 10. The status register is mirrored onto the outbound observation lines, so a sender can tell whether its request has been taken. The inbound observation lines of the peers can be read back through the observation register. All state changes on the rising clock edge, and reset is synchronous and active-high. Read data is combinational from the address, so it needs no wait cycle.

Top module: `xirq_hub`

## Requirements
- R1: After reset the status is 0, the mask register reads 0x0F0F0301 (every channel masked), and irqOut, trigOut and obsOut are all 0.
- R2: A write to offset 0x00 raises trigOut[c] for exactly the one cycle after the write edge, for every channel c whose bit is set in the write data. Bits outside the channel positions have no effect, and offset 0x00 always reads 0.
- R3: Offset 0x04 reads obsIn placed on the channel bit positions. Writes to it change nothing.
- R4: A high reqIn[c] sets status bit c at the next edge. The bit stays set after the request drops, and status reads back at offset 0x10.
- R5: Writing a 1 to a channel bit of offset 0x10 clears that status bit. Writing a 0 leaves it unchanged.
- R6: When reqIn[c] is high in the same cycle as a write-one-to-clear of status bit c, the bit stays set.
- R7: The mask register at 0x14 is read-only. Writes to it leave it unchanged.
- R8: Writing a 1 to a channel bit at 0x18 clears that mask bit, and writing a 1 at 0x1C sets it. Both offsets read 0.
- R9: irqOut is a register. One cycle after any status or mask change it equals the OR over channels of (status AND NOT mask).
- R10: obsOut[c] equals the current status bit c.
- R11: Unmapped offsets read 0 and ignore writes. Bits outside the valid mask 0x0F0F0301 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the access (word aligned) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| reqIn | input | 11 | Inbound request lines, one per channel |
| obsIn | input | 11 | Inbound observation lines, one per channel |
| trigOut | output | 11 | Outbound one-cycle trigger pulses |
| obsOut | output | 11 | Status mirror toward senders |
| irqOut | output | 1 | Registered combined interrupt |

## Verification
The bench first aims at the race between an incoming request and a write-one-to-clear to the same bit. A design that gives the clear priority silently loses that event, and status reads back as zero. It checks that irqOut moves exactly one cycle after a status or mask change. An unregistered output, or one that is a cycle late, is caught in both directions. It also checks that a trigger write produces a single-cycle pulse and not a held level. Finally, writes to the read-only mask, to reserved bits and to unmapped offsets must leave every readable register unchanged.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam int REG_W = 32;

  // Word offsets of the register window
  localparam int OFF_TRIG = 'h00;
  localparam int OFF_OBS  = 'h04;
  localparam int OFF_STAT = 'h10;
  localparam int OFF_MASK = 'h14;
  localparam int OFF_EN   = 'h18;
  localparam int OFF_DIS  = 'h1C;

  typedef enum logic [1:0] {
    SEL_ZERO,
    SEL_OBS,
    SEL_STAT,
    SEL_MASK
  } rdSel_e;

  typedef struct packed {
    logic trigWr;
    logic statClr;
    logic maskEn;
    logic maskDis;
  } strobe_t;

  // Bit position of a channel inside every register word
  function automatic int chanPos(input int ch);
    if (ch == 0) return 0;
    else if (ch < 3) return ch + 7;
    else if (ch < 7) return ch + 13;
    else return ch + 17;
  endfunction

  function automatic logic [REG_W-1:0] validMask(input int numCh);
    logic [REG_W-1:0] m;
    m = '0;
    for (int c = 0; c < numCh; c++) m[chanPos(c)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strobe,
  output rdSel_e            rdSel
);

  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFF_TRIG);
  localparam logic [ADDR_W-1:0] A_OBS  = ADDR_W'(OFF_OBS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFF_DIS);

  logic [ADDR_W-1:0] wordAddr;
  assign wordAddr = {addr[ADDR_W-1:2], 2'b00};

  always_comb begin
    strobe.trigWr  = wrEn && (wordAddr == A_TRIG);
    strobe.statClr = wrEn && (wordAddr == A_STAT);
    strobe.maskEn  = wrEn && (wordAddr == A_EN);
    strobe.maskDis = wrEn && (wordAddr == A_DIS);
  end

  always_comb begin
    unique case (wordAddr)
      A_OBS:   rdSel = SEL_OBS;
      A_STAT:  rdSel = SEL_STAT;
      A_MASK:  rdSel = SEL_MASK;
      default: rdSel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/xirq_datapath.sv
module xirq_datapath
  import xirq_pkg::*;
#(
  parameter int NUM_CH = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  rdSel_e            rdSel,
  input  logic [REG_W-1:0]  wrData,
  input  logic [NUM_CH-1:0] reqIn,
  input  logic [NUM_CH-1:0] obsIn,
  output logic [REG_W-1:0]  rdData,
  output logic [NUM_CH-1:0] trigOut,
  output logic [NUM_CH-1:0] obsOut,
  output logic [NUM_CH-1:0] maskChan,
  output logic              irqOut
);

  logic [NUM_CH-1:0] selChan;
  logic [NUM_CH-1:0] clrChan;
  logic [NUM_CH-1:0] trigQ;
  logic [NUM_CH-1:0] statQ;
  logic [NUM_CH-1:0] maskQ;
  logic              irqQ;
  logic [REG_W-1:0]  obsWord;
  logic [REG_W-1:0]  statWord;
  logic [REG_W-1:0]  maskWord;

  // Pick channel bits out of the write word
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
    localparam int POS = chanPos(ch);
    assign selChan[ch] = wrData[POS];
  end

  assign clrChan = strobe.statClr ? selChan : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      trigQ <= '0;
      statQ <= '0;
      maskQ <= '1;
      irqQ  <= 1'b0;
    end else begin
      trigQ <= strobe.trigWr ? selChan : '0;
      statQ <= (statQ & ~clrChan) | reqIn;   // set beats clear
      if (strobe.maskEn)       maskQ <= maskQ & ~selChan;
      else if (strobe.maskDis) maskQ <= maskQ | selChan;
      irqQ  <= |(statQ & ~maskQ);
    end
  end

  // Place channel vectors back onto their word positions
  always_comb begin
    obsWord  = '0;
    statWord = '0;
    maskWord = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      obsWord[chanPos(c)]  = obsIn[c];
      statWord[chanPos(c)] = statQ[c];
      maskWord[chanPos(c)] = maskQ[c];
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_OBS:  rdData = obsWord;
      SEL_STAT: rdData = statWord;
      SEL_MASK: rdData = maskWord;
      default:  rdData = '0;
    endcase
  end

  assign trigOut  = trigQ;
  assign obsOut   = statQ;
  assign maskChan = maskQ;
  assign irqOut   = irqQ;

endmodule

// File: rtl/xirq_hub.sv
module xirq_hub
  import xirq_pkg::*;
#(
  parameter int NUM_CH = 11,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [NUM_CH-1:0] reqIn,
  input  logic [NUM_CH-1:0] obsIn,
  output logic [NUM_CH-1:0] trigOut,
  output logic [NUM_CH-1:0] obsOut,
  output logic              irqOut
);

  strobe_t           strobe;
  rdSel_e            rdSel;
  logic [NUM_CH-1:0] maskChan;

  xirq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  xirq_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .rdSel    (rdSel),
    .wrData   (wrData),
    .reqIn    (reqIn),
    .obsIn    (obsIn),
    .rdData   (rdData),
    .trigOut  (trigOut),
    .obsOut   (obsOut),
    .maskChan (maskChan),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/xirq_hub_chk.sv
module xirq_hub_chk
  import xirq_pkg::*;
#(
  parameter int NUM_CH = 11,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  rdData,
  input logic [NUM_CH-1:0] reqIn,
  input logic [NUM_CH-1:0] trigOut,
  input logic [NUM_CH-1:0] obsOut,
  input logic [NUM_CH-1:0] maskState,
  input logic              irqOut
);

  localparam logic [REG_W-1:0] VALID = validMask(NUM_CH);

  logic [ADDR_W-1:0] wa;
  logic isTrig, isObs, isStat, isMask, isEn, isDis;
  assign wa     = {addr[ADDR_W-1:2], 2'b00};
  assign isTrig = (wa == ADDR_W'(OFF_TRIG));
  assign isObs  = (wa == ADDR_W'(OFF_OBS));
  assign isStat = (wa == ADDR_W'(OFF_STAT));
  assign isMask = (wa == ADDR_W'(OFF_MASK));
  assign isEn   = (wa == ADDR_W'(OFF_EN));
  assign isDis  = (wa == ADDR_W'(OFF_DIS));

  assert_trig_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && isTrig) |=> (trigOut == '0));

  assert_status_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && isStat) |=> ((obsOut & $past(obsOut)) == $past(obsOut)));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (|reqIn) |=> ((obsOut & $past(reqIn)) == $past(reqIn)));

  assert_mask_readonly_R7: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && (isEn || isDis)) |=> $stable(maskState));

  assert_strobe_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (isTrig || isEn || isDis) |-> (rdData == '0));

  assert_irq_registered_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irqOut == $past(|(obsOut & ~maskState))));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !(isTrig || isObs || isStat || isMask || isEn || isDis) |-> (rdData == '0));

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (rst)
    ((rdData & ~VALID) == '0));

endmodule

bind xirq_hub xirq_hub_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wrEn      (wrEn),
  .addr      (addr),
  .rdData    (rdData),
  .reqIn     (reqIn),
  .trigOut   (trigOut),
  .obsOut    (obsOut),
  .maskState (maskChan),
  .irqOut    (irqOut)
);

// File: tb/xirq_hub_tb.sv
`timescale 1ns/1ps
module xirq_hub_tb;

  localparam int NCH = 11;
  localparam int AW  = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wrEn = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wrData = '0;
  logic [31:0]     rdData;
  logic [NCH-1:0]  reqIn = '0;
  logic [NCH-1:0]  obsIn = '0;
  logic [NCH-1:0]  trigOut;
  logic [NCH-1:0]  obsOut;
  logic            irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  xirq_hub #(.NUM_CH(NCH), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .reqIn(reqIn), .obsIn(obsIn), .trigOut(trigOut),
    .obsOut(obsOut), .irqOut(irqOut)
  );

  typedef struct packed {
    logic           wr;
    logic [7:0]     wAddr;
    logic [31:0]    wData;
    logic [NCH-1:0] req;
    logic [7:0]     rAddr;
    logic [31:0]    exp;
    logic [7:0]     tag;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 8'h00, 32'h0,          11'h008, 8'h10, 32'h00010000, 8'd4},  // R4
    '{1'b1, 8'h10, 32'h0,          11'h000, 8'h10, 32'h00010000, 8'd5},  // R5 write 0
    '{1'b1, 8'h10, 32'h00010000,   11'h000, 8'h10, 32'h00000000, 8'd5},  // R5 clear
    '{1'b0, 8'h00, 32'h0,          11'h401, 8'h10, 32'h08000001, 8'd4},  // R4
    '{1'b1, 8'h14, 32'h0,          11'h000, 8'h14, 32'h0F0F0301, 8'd7},  // R7
    '{1'b1, 8'h18, 32'h00000001,   11'h000, 8'h14, 32'h0F0F0300, 8'd8},  // R8 enable
    '{1'b1, 8'h1C, 32'h00000001,   11'h000, 8'h14, 32'h0F0F0301, 8'd8},  // R8 disable
    '{1'b1, 8'h18, 32'hFFFFFFFF,   11'h000, 8'h18, 32'h00000000, 8'd8},  // R8 reads 0
    '{1'b0, 8'h00, 32'h0,          11'h000, 8'h14, 32'h00000000, 8'd8},  // R8
    '{1'b1, 8'h40, 32'hFFFFFFFF,   11'h000, 8'h40, 32'h00000000, 8'd11}, // R11
    '{1'b1, 8'h10, 32'hFFFFFFFF,   11'h000, 8'h10, 32'h00000000, 8'd5},  // R5
    '{1'b1, 8'h1C, 32'hF0F0FCFE,   11'h000, 8'h14, 32'h00000000, 8'd11}, // R11 reserved
    '{1'b1, 8'h1C, 32'h0F0F0301,   11'h000, 8'h14, 32'h0F0F0301, 8'd8}   // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    readReg(8'h14, d); check("R1 mask", d, 32'h0F0F0301);
    readReg(8'h10, d); check("R1 status", d, 32'h0);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);
    check("R1 trigOut", {21'b0, trigOut}, 32'h0);
    check("R1 obsOut", {21'b0, obsOut}, 32'h0);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wrEn = VECS[i].wr; addr = VECS[i].wAddr; wrData = VECS[i].wData; reqIn = VECS[i].req;
      @(negedge clk);
      wrEn = 1'b0; reqIn = '0;
      readReg(VECS[i].rAddr, d);
      check($sformatf("R%0d vector %0d", VECS[i].tag, i), d, VECS[i].exp);
    end

    // R2 trigger pulse: bits 8,16,18,25 plus reserved bits
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h00; wrData = 32'h02050100 | 32'hF0F0FCFE;
    @(negedge clk);
    wrEn = 1'b0;
    check("R2 pulse high", {21'b0, trigOut}, 32'h12A);
    @(negedge clk);
    check("R2 pulse gone", {21'b0, trigOut}, 32'h0);
    readReg(8'h00, d); check("R2 trigger reads zero", d, 32'h0);

    // R3 observation
    obsIn = 11'h4C1;
    readReg(8'h04, d); check("R3 obs read", d, 32'h09080001);
    writeReg(8'h04, 32'h0);
    readReg(8'h04, d); check("R3 obs write ignored", d, 32'h09080001);
    obsIn = '0;

    // R9/R10 unmasked request on channel 2 (bit 9)
    writeReg(8'h18, 32'h00000200);
    reqIn = 11'h004;
    @(negedge clk);
    reqIn = '0;
    check("R10 obsOut mirrors", {21'b0, obsOut}, 32'h004);
    check("R9 irq not yet", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check("R9 irq one cycle later", {31'b0, irqOut}, 32'h1);
    writeReg(8'h10, 32'h00000200);
    check("R10 obsOut cleared", {21'b0, obsOut}, 32'h0);
    check("R9 irq still high", {31'b0, irqOut}, 32'h1);
    @(negedge clk);
    check("R9 irq dropped", {31'b0, irqOut}, 32'h0);

    // R9 masked request on channel 4 (bit 17), then unmask
    @(negedge clk);
    reqIn = 11'h010;
    @(negedge clk);
    reqIn = '0;
    @(negedge clk);
    check("R9 masked irq low", {31'b0, irqOut}, 32'h0);
    check("R10 masked still pending", {21'b0, obsOut}, 32'h010);
    writeReg(8'h18, 32'h00020000);
    check("R9 irq before unmask seen", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check("R9 irq after unmask", {31'b0, irqOut}, 32'h1);
    writeReg(8'h10, 32'h00020000);
    @(negedge clk);
    check("R9 irq after clear", {31'b0, irqOut}, 32'h0);

    // R6 set wins over clear on channel 7 (bit 24)
    @(negedge clk);
    reqIn = 11'h080; wrEn = 1'b1; addr = 8'h10; wrData = 32'h01000000;
    @(negedge clk);
    reqIn = '0; wrEn = 1'b0;
    check("R6 obsOut kept", {21'b0, obsOut}, 32'h080);
    readReg(8'h10, d); check("R6 status kept", d, 32'h01000000);
    writeReg(8'h10, 32'h01000000);
    check("R5 cleared afterwards", {21'b0, obsOut}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule